// File: doc/BRIEF.md
# Graphics Status Register and Alignment Unit

This block owns a 64-bit graphics status register and carries out the small set of operations that read or modify it. Some operations add two 64-bit operands to form an address, give back a trimmed form of that sum and store part of it in a field of the register. Others replace the rounding-mode bits, overwrite the whole register or return its contents. One operation uses the stored byte offset to extract an unaligned 8-byte window from a 16-byte pair of operands.

The caller presents an opcode and two operands along with a one-cycle start pulse. On the next clock edge the unit updates the register fields the operation targets and registers its integer and data results. In the following cycle it raises a one-cycle done flag. Every other field of the register keeps its value. The register layout is: byte offset in bits [2:0], scale in bits [7:3] (kept but never written by a field operation), rounding-mode control in bits [27:25] (mode in [26:25], enable in bit 27) and the shuffle mask in bits [63:32].

Top module: `gsr_align_unit`

## Requirements
- R1: After reset, done is 0, both result ports read 0 and the status register holds 0.
- R2: done is 1 in exactly the cycle after a cycle with start high, and 0 after any cycle with start low. Results change only in the cycle after start and hold their values otherwise.
- R3: Opcode 0 (align address) returns the operand sum with bits [2:0] cleared on the integer port and 0 on the data port. It writes sum[2:0] into register bits [2:0] and leaves bits [63:3] unchanged.
- R4: Opcode 1 (little-endian align address) returns the same integer result as R3. It writes (8 - sum[2:0]) mod 8 into bits [2:0] and leaves the other bits unchanged.
- R5: Opcode 2 (set mask) returns the full 64-bit sum on the integer port. It loads sum[31:0] into bits [63:32] and leaves bits [31:0] unchanged.
- R6: Opcode 3 (set rounding) writes operand B bits [2:0] into register bits [27:25] and leaves the other bits unchanged. Both result ports read 0.
- R7: Opcode 4 (extract) returns, on the data port, bytes k..k+7 of the 16-byte string formed by operand A followed by operand B. Byte 0 is A[63:56], and k is the offset held in the register when start is sampled. This includes an offset written by an operation started one cycle earlier.
- R8: Opcode 5 (write) loads A XOR B into all 64 register bits. Both result ports read 0.
- R9: Opcode 6 (read) returns the register on the integer port and leaves the register unchanged.
- R10: Opcode 7 is reserved. It still produces done, drives both result ports to 0 and leaves the register unchanged.
- R11: The operand sum is taken modulo 2^64, so a carry out of bit 63 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request strobe |
| op_code | input | 3 | Operation select (encoding in R3 to R10) |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand; bits [2:0] also carry the rounding value |
| int_res | output | 64 | Integer result |
| data_res | output | 64 | Extracted data result |
| done | output | 1 | Completion pulse, one cycle after start |

## Verification
The extract reads the byte offset in the same cycle in which a preceding align-address operation writes it. Likewise, a register read can directly follow a full-register write. The bench issues such pairs on consecutive cycles with no idle cycle between them. It judges the second result against a value built from the offset or register contents the first operation must have left behind. A stale offset gives a different window, because the chosen operand bytes are all distinct.

// File: rtl/gsr_pkg.sv
// Package: shared opcode type and status register field positions.
// Assumes a 64-bit register with the byte offset at the bottom.
package gsr_pkg;

    typedef enum logic [2:0] {
        OP_ALIGN    = 3'd0,
        OP_ALIGN_LE = 3'd1,
        OP_SETMASK  = 3'd2,
        OP_SETRND   = 3'd3,
        OP_EXTRACT  = 3'd4,
        OP_WRITE    = 3'd5,
        OP_READ     = 3'd6,
        OP_RSVD     = 3'd7
    } gsr_op_e;

    localparam int RND_LSB = 25;
    localparam int RND_W   = 3;
    localparam int MSK_LSB = 32;

endpackage

// File: rtl/gsr_addr_unit.sv
// Address adder: forms the operand sum, the sum with its offset bits
// cleared, and the byte offset in both endian conventions.
// Assumes DW is a multiple of 8; purely combinational.
module gsr_addr_unit #(
    parameter int DW = 64,
    localparam int NB   = DW / 8,
    localparam int OFFW = $clog2(NB)
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   sum,
    output logic [DW-1:0]   sum_aligned,
    output logic [OFFW-1:0] off_be,
    output logic [OFFW-1:0] off_le
);
    logic [OFFW-1:0] low;

    // Modulo-2^DW sum and its derived offsets
    always_comb begin
        sum         = a + b;
        low         = sum[OFFW-1:0];
        sum_aligned = {sum[DW-1:OFFW], {OFFW{1'b0}}};
        off_be      = low;
        off_le      = ~low + {{(OFFW-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/gsr_extract.sv
// Byte-window extractor: picks NB consecutive bytes from the 2*NB-byte
// string {a, b}, starting at byte offset off (byte 0 = a's top byte).
// Assumes off < NB; purely combinational.
module gsr_extract #(
    parameter int DW = 64,
    localparam int NB   = DW / 8,
    localparam int OFFW = $clog2(NB)
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [OFFW-1:0] off,
    output logic [DW-1:0]   res
);
    logic [2*DW-1:0] cat;

    // Join the operands into one byte string
    always_comb cat = {a, b};

    for (genvar j = 0; j < NB; j++) begin : g_byte
        int unsigned idx;
        // Source byte position for output byte j
        always_comb idx = int'(off) + j;
        // Select that byte into output lane j
        always_comb res[DW-1-8*j -: 8] = cat[2*DW-1-8*idx -: 8];
    end

    // A zero offset must pass operand a through untouched (R7)
    always_comb begin
        if (off == '0) begin
            AST_EXT_IDENT: assert (res == a); // R7
        end
    end

endmodule

// File: rtl/gsr_state.sv
// Status register: holds the 64-bit register and applies one field
// update per cycle. Assumes at most one write enable is high per cycle.
module gsr_state #(
    parameter int DW = 64,
    localparam int NB   = DW / 8,
    localparam int OFFW = $clog2(NB),
    localparam int MW   = DW - gsr_pkg::MSK_LSB,
    localparam int RL   = gsr_pkg::RND_LSB,
    localparam int RW   = gsr_pkg::RND_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_off,
    input  logic [OFFW-1:0] off_val,
    input  logic            we_mask,
    input  logic [MW-1:0]   mask_val,
    input  logic            we_rnd,
    input  logic [RW-1:0]   rnd_val,
    input  logic            we_all,
    input  logic [DW-1:0]   all_val,
    output logic [DW-1:0]   gsr
);
    localparam int ML = gsr_pkg::MSK_LSB;

    // Register update: whole write or a single field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gsr <= '0;
        end else if (we_all) begin
            gsr <= all_val;
        end else begin
            if (we_off)  gsr[OFFW-1:0]    <= off_val;
            if (we_mask) gsr[DW-1:ML]     <= mask_val;
            if (we_rnd)  gsr[RL+RW-1:RL]  <= rnd_val;
        end
    end

    AST_OFF_KEEP_REST: assert property (@(posedge clk) disable iff (!rst_n)
        we_off |=> gsr[DW-1:OFFW] == $past(gsr[DW-1:OFFW])); // R3

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_mask |=> (gsr[DW-1:ML] == $past(mask_val)) &&
                    (gsr[ML-1:0] == $past(gsr[ML-1:0]))); // R5

    AST_RND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_rnd |=> (gsr[RL+RW-1:RL] == $past(rnd_val)) &&
                   (gsr[RL-1:0] == $past(gsr[RL-1:0]))); // R6

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_all |=> gsr == $past(all_val)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_off || we_mask || we_rnd || we_all) |=> $stable(gsr)); // R10

endmodule

// File: rtl/gsr_align_unit.sv
// Top: decodes the opcode, drives the status register field updates
// and registers the results, raising done one cycle after start.
// Assumes start is a single-cycle strobe with stable operands.
module gsr_align_unit #(
    parameter int DW = 64,
    localparam int NB   = DW / 8,
    localparam int OFFW = $clog2(NB),
    localparam int MW   = DW - gsr_pkg::MSK_LSB,
    localparam int RW   = gsr_pkg::RND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_code,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic [DW-1:0] int_res,
    output logic [DW-1:0] data_res,
    output logic          done
);
    import gsr_pkg::*;

    gsr_op_e         op;
    logic [DW-1:0]   sum, sum_aligned, gsr, ext;
    logic [OFFW-1:0] off_be, off_le, off_new;
    logic            we_off, we_mask, we_rnd, we_all;

    // Opcode cast and write-enable decode
    always_comb begin
        op      = gsr_op_e'(op_code);
        we_off  = start && (op == OP_ALIGN || op == OP_ALIGN_LE);
        we_mask = start && (op == OP_SETMASK);
        we_rnd  = start && (op == OP_SETRND);
        we_all  = start && (op == OP_WRITE);
        off_new = (op == OP_ALIGN_LE) ? off_le : off_be;
    end

    gsr_addr_unit #(.DW(DW)) u_addr (
        .a(opnd_a), .b(opnd_b), .sum(sum), .sum_aligned(sum_aligned),
        .off_be(off_be), .off_le(off_le)
    );

    gsr_extract #(.DW(DW)) u_ext (
        .a(opnd_a), .b(opnd_b), .off(gsr[OFFW-1:0]), .res(ext)
    );

    gsr_state #(.DW(DW)) u_state (
        .clk(clk), .rst_n(rst_n),
        .we_off(we_off), .off_val(off_new),
        .we_mask(we_mask), .mask_val(sum[MW-1:0]),
        .we_rnd(we_rnd), .rnd_val(opnd_b[RW-1:0]),
        .we_all(we_all), .all_val(opnd_a ^ opnd_b),
        .gsr(gsr)
    );

    // Result registers and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            int_res  <= '0;
            data_res <= '0;
        end else begin
            done <= start;
            if (start) begin
                int_res  <= '0;
                data_res <= '0;
                case (op)
                    OP_ALIGN, OP_ALIGN_LE: int_res  <= sum_aligned;
                    OP_SETMASK:            int_res  <= sum;
                    OP_EXTRACT:            data_res <= ext;
                    OP_READ:               int_res  <= gsr;
                    default:               ;
                endcase
            end
        end
    end

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done); // R2

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(int_res) && $stable(data_res)); // R2

    AST_ALIGN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == OP_ALIGN || op == OP_ALIGN_LE))
            |=> int_res[OFFW-1:0] == '0); // R3

endmodule

// File: tb/tb_gsr_align_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_gsr_align_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [63:0] int_res, data_res;
    logic        done;

    int n_chk = 0, n_fail = 0;
    bit fin = 0;
    logic [63:0] r_int, r_data;
    logic        r_done;

    localparam logic [63:0] XA = 64'h0011_2233_4455_6677;
    localparam logic [63:0] XB = 64'h8899_AABB_CCDD_EEFF;

    always #10 clk = ~clk;

    gsr_align_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .int_res(int_res),
        .data_res(data_res), .done(done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ext_model(input logic [63:0] a, b, input int k);
        logic [127:0] c;
        c = {a, b} << (8 * k);
        return c[127:64];
    endfunction

    task automatic issue(input logic [2:0] o, input logic [63:0] a, b);
        @(negedge clk);
        start = 1'b1; op_code = o; opnd_a = a; opnd_b = b;
        @(negedge clk);
        start = 1'b0;
        r_done = done; r_int = int_res; r_data = data_res;
    endtask

    task automatic read_gsr(output logic [63:0] g);
        issue(3'd6, 64'h5555, 64'hAAAA);
        g = r_int;
    endtask

    task automatic t_reset;
        logic [63:0] g;
        chk("R1 done", {63'd0, done}, 64'd0);
        chk("R1 int_res", int_res, 64'd0);
        chk("R1 data_res", data_res, 64'd0);
        rst_n = 1'b1;
        read_gsr(g);
        chk("R1 gsr zero", g, 64'd0);
        chk("R9 read done", {63'd0, r_done}, 64'd1);
    endtask

    task automatic t_align;
        logic [63:0] g;
        issue(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        issue(3'd0, 64'h1000, 64'h0D);
        chk("R3 int", r_int, 64'h1008);
        chk("R3 data zero", r_data, 64'd0);
        read_gsr(g);
        chk("R3 gsr", g, 64'hFFFF_FFFF_FFFF_FFFD);
        issue(3'd1, 64'h2000, 64'h03);
        chk("R4 int", r_int, 64'h2000);
        read_gsr(g);
        chk("R4 gsr off 5", g, 64'hFFFF_FFFF_FFFF_FFFD);
        issue(3'd1, 64'h40, 64'h01);
        read_gsr(g);
        chk("R4 gsr off 7", g, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(3'd1, 64'h18, 64'h00);
        read_gsr(g);
        chk("R4 gsr off 0", g, 64'hFFFF_FFFF_FFFF_FFF8);
    endtask

    task automatic t_wrap;
        logic [63:0] g;
        issue(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
        chk("R11 align int", r_int, 64'd0);
        read_gsr(g);
        chk("R11 align off", {61'd0, g[2:0]}, 64'd1);
        issue(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
        chk("R11 mask int", r_int, 64'd2);
    endtask

    task automatic t_mask;
        logic [63:0] g;
        issue(3'd5, 64'h0, 64'h0000_0000_1234_5678);
        issue(3'd2, 64'h1_2345_0000, 64'h6789);
        chk("R5 int", r_int, 64'h1_2345_6789);
        read_gsr(g);
        chk("R5 gsr", g, 64'h2345_6789_1234_5678);
    endtask

    task automatic t_rnd;
        logic [63:0] g;
        issue(3'd5, 64'h0, 64'h0F00_00FF);
        issue(3'd3, 64'hDEAD_BEEF, 64'hFFFF_FFF5);
        chk("R6 int zero", r_int, 64'd0);
        chk("R6 data zero", r_data, 64'd0);
        read_gsr(g);
        chk("R6 gsr", g, 64'h0B00_00FF);
    endtask

    task automatic t_extract;
        for (int k = 0; k < 8; k += 3) begin
            issue(3'd0, 64'(k), 64'd0);
            issue(3'd4, XA, XB);
            chk("R7 extract", r_data, ext_model(XA, XB, k));
            chk("R7 int zero", r_int, 64'd0);
        end
        issue(3'd0, 64'd7, 64'd0);
        issue(3'd4, XA, XB);
        chk("R7 extract off 7", r_data, 64'h7788_99AA_BBCC_DDEE);
    endtask

    task automatic t_b2b;
        @(negedge clk);
        start = 1'b1; op_code = 3'd0; opnd_a = 64'h100; opnd_b = 64'h6;
        @(negedge clk);
        op_code = 3'd4; opnd_a = XA; opnd_b = XB;
        chk("R3 b2b int", int_res, 64'h100);
        @(negedge clk);
        start = 1'b0;
        chk("R7 b2b done", {63'd0, done}, 64'd1);
        chk("R7 b2b extract", data_res, ext_model(XA, XB, 6));
        @(negedge clk);
        start = 1'b1; op_code = 3'd5; opnd_a = 64'hA5A5_0000_FFFF_1234; opnd_b = 64'h0F0F_0F0F_0F0F_0F0F;
        @(negedge clk);
        op_code = 3'd6;
        @(negedge clk);
        start = 1'b0;
        chk("R8 b2b write/read", int_res, 64'hAAAA_0F0F_F0F0_1D3B);
    endtask

    task automatic t_reserved;
        logic [63:0] g0, g1;
        read_gsr(g0);
        issue(3'd7, 64'h1234, 64'h7);
        chk("R10 done", {63'd0, r_done}, 64'd1);
        chk("R10 int", r_int, 64'd0);
        chk("R10 data", r_data, 64'd0);
        read_gsr(g1);
        chk("R10 gsr kept", g1, g0);
        chk("R9 read unchanged", g1, 64'hAAAA_0F0F_F0F0_1D3B);
    endtask

    task automatic t_idle;
        issue(3'd2, 64'h10, 64'h20);
        @(negedge clk);
        chk("R2 done one cycle", {63'd0, done}, 64'd0);
        chk("R2 result held", int_res, 64'h30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_align();
        t_wrap();
        t_mask();
        t_rnd();
        t_extract();
        t_b2b();
        t_reserved();
        t_idle();
        if (!fin) begin
            fin = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!fin) begin
            fin = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule